// File: doc/BRIEF.md
# Reference-Counted Pad Isolation Sequencer

This block owns the three power-isolation controls of an I/O pad domain: a core-supply-off indication, an early clamp and a final clamp, all active high. Several clients share the domain. Each client raises a one-cycle enable request when it needs the pads and a one-cycle disable request when it is finished. The block counts the clients that hold the domain. It runs a timed release sequence only for the first holder, and a timed assert sequence only when the last holder leaves.

The two sequences are mirror images. Release drops the clamp, then the early clamp, then the core-supply-off control. Assert raises the same three controls in the opposite order. A fixed wait of `DELAY_CYCLES` clock cycles separates consecutive steps. While a sequence runs, `busy` is high and every request is dropped, so a client must retry. A disable that has no matching enable, or an enable that would overflow the count, sets a sticky error flag. A dedicated clear pulse resets that flag.

Top module: `pad_iso_seq`

## Requirements
- R1: After reset the usage count is zero, `iso_word` bits 31 (core-supply-off), 30 (early clamp) and 29 (clamp) are 1, every other `iso_word` bit is 0, and `busy` and `unbal_err` are 0. Bits other than 31..29 stay 0 at all times.
- R2: An accepted enable while the count is zero increments the count and starts the release sequence. Bit 29 clears on the accepting clock edge, bit 30 clears `DELAY_CYCLES` edges later, and bit 31 clears `DELAY_CYCLES` edges after that.
- R3: An accepted enable while the count is non-zero and below its maximum increments the count and leaves `iso_word` and `busy` unchanged.
- R4: An accepted disable while the count is two or more decrements the count and leaves `iso_word` and `busy` unchanged.
- R5: An accepted disable while the count is one brings the count to zero and starts the assert sequence. Bit 31 sets on the accepting edge, bit 30 sets `DELAY_CYCLES` edges later, and bit 29 sets `DELAY_CYCLES` edges after that.
- R6: `busy` is high from the edge that starts a sequence until the edge of its last step, which is 2·`DELAY_CYCLES` cycles. Requests presented while `busy` is high are ignored and do not change the count.
- R7: A disable while the count is zero leaves the count and `iso_word` unchanged and sets `unbal_err`.
- R8: `unbal_err` stays set until a one-cycle `err_clr` pulse clears it. If a new error happens in the same cycle as the clear, the flag stays set.
- R9: An enable while the count is at its maximum (2^`CNT_W`−1) is rejected. The count and `iso_word` stay unchanged and `unbal_err` is set.
- R10: An enable and a disable presented in the same cycle cancel each other. The count, `iso_word` and `unbal_err` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | One-cycle request to take a hold on the pad domain |
| dis_req | input | 1 | One-cycle request to drop a hold on the pad domain |
| err_clr | input | 1 | One-cycle clear of the sticky error flag |
| iso_word | output | 32 | Control word; bit 31 core-supply-off, bit 30 early clamp, bit 29 clamp |
| busy | output | 1 | A release or assert sequence is in progress |
| unbal_err | output | 1 | Sticky flag for an unmatched disable or a count overflow |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a sequence. The only evidence that such a request was dropped is what the block does next. The bench fires a disable while a release sequence is still running. After the block goes idle, it sends one more disable and expects an assert sequence to start with no error flagged; that outcome shows the earlier disable never reached the count. Count overflow is reached by building the bench with a two-bit count, so three enables fill it.

// File: rtl/pad_iso_pkg.sv
package pad_iso_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned VCORE_BIT = 31;
    localparam int unsigned EARLY_BIT = 30;
    localparam int unsigned CLAMP_BIT = 29;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_UP_A  = 3'd1,
        ST_UP_B  = 3'd2,
        ST_DN_A  = 3'd3,
        ST_DN_B  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic vcore;
        logic early;
        logic clamp;
    } iso_ctrl_t;

    localparam iso_ctrl_t CTRL_CLAMPED  = '{vcore: 1'b1, early: 1'b1, clamp: 1'b1};
    localparam iso_ctrl_t CTRL_RELEASED = '{vcore: 1'b0, early: 1'b0, clamp: 1'b0};

endpackage

// File: rtl/pad_iso_timer.sv
module pad_iso_timer #(
    parameter int unsigned DELAY_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int unsigned TW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [TW-1:0] LOAD_VAL = TW'(DELAY_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        done  = cur_q.run && (cur_q.cnt == '0);
        if (load) begin
            nxt_d.run = 1'b1;
            nxt_d.cnt = LOAD_VAL;
        end else if (done) begin
            nxt_d.run = 1'b0;
        end else if (cur_q.run) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !done);

endmodule

// File: rtl/pad_iso_usage.sv
module pad_iso_usage #(
    parameter int unsigned CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic err_clr,
    input  logic busy,
    output logic start_up,
    output logic start_dn,
    output logic unbal_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } use_t;

    use_t cur_q, nxt_d;
    logic err_evt;
    logic accept;

    always_comb begin
        nxt_d    = cur_q;
        start_up = 1'b0;
        start_dn = 1'b0;
        err_evt  = 1'b0;
        accept   = !busy && (en_req ^ dis_req);
        if (accept) begin
            if (en_req) begin
                if (cur_q.cnt == CNT_MAX) begin
                    err_evt = 1'b1;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                    start_up  = (cur_q.cnt == '0);
                end
            end else begin
                if (cur_q.cnt == '0) begin
                    err_evt = 1'b1;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                    start_dn  = (cur_q.cnt == CNT_ONE);
                end
            end
        end
        if (err_clr) nxt_d.err = 1'b0;
        if (err_evt) nxt_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign unbal_err = cur_q.err;

    // R7
    zero_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_req && !en_req && !busy && cur_q.cnt == '0) |=> (cur_q.cnt == '0 && cur_q.err));

    // R9
    full_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req && !dis_req && !busy && cur_q.cnt == CNT_MAX) |=> (cur_q.cnt == CNT_MAX && cur_q.err));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_q.cnt));

    // R10
    both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req && dis_req && !err_clr) |=> ($stable(cur_q.cnt) && $stable(cur_q.err)));

endmodule

// File: rtl/pad_iso_steps.sv
module pad_iso_steps
    import pad_iso_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_up,
    input  logic      start_dn,
    input  logic      tmr_done,
    output logic      tmr_load,
    output logic      busy,
    output iso_ctrl_t ctrl
);
    typedef struct packed {
        seq_state_e st;
        iso_ctrl_t  ctrl;
    } step_t;

    step_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start_up) begin
                    nxt_d.ctrl.clamp = 1'b0;
                    nxt_d.st         = ST_UP_A;
                    tmr_load         = 1'b1;
                end else if (start_dn) begin
                    nxt_d.ctrl.vcore = 1'b1;
                    nxt_d.st         = ST_DN_A;
                    tmr_load         = 1'b1;
                end
            end
            ST_UP_A: if (tmr_done) begin
                nxt_d.ctrl.early = 1'b0;
                nxt_d.st         = ST_UP_B;
                tmr_load         = 1'b1;
            end
            ST_UP_B: if (tmr_done) begin
                nxt_d.ctrl.vcore = 1'b0;
                nxt_d.st         = ST_IDLE;
            end
            ST_DN_A: if (tmr_done) begin
                nxt_d.ctrl.early = 1'b1;
                nxt_d.st         = ST_DN_B;
                tmr_load         = 1'b1;
            end
            ST_DN_B: if (tmr_done) begin
                nxt_d.ctrl.clamp = 1'b1;
                nxt_d.st         = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.ctrl <= CTRL_CLAMPED;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy = (cur_q.st != ST_IDLE);
    assign ctrl = cur_q.ctrl;

    // R2
    vcore_last_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.ctrl.vcore) |-> (!cur_q.ctrl.early && !cur_q.ctrl.clamp));

    // R5
    clamp_last_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.ctrl.clamp) |-> (cur_q.ctrl.vcore && cur_q.ctrl.early));

    // R6
    uniform_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cur_q.ctrl == CTRL_CLAMPED || cur_q.ctrl == CTRL_RELEASED));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_up && !start_dn) |=> $stable(cur_q.ctrl));

    // R6
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!start_up && !start_dn));

endmodule

// File: rtl/pad_iso_seq.sv
module pad_iso_seq
    import pad_iso_pkg::*;
#(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned DELAY_CYCLES = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic              err_clr,
    output logic [WORD_W-1:0] iso_word,
    output logic              busy,
    output logic              unbal_err
);
    logic      start_up;
    logic      start_dn;
    logic      tmr_load;
    logic      tmr_done;
    iso_ctrl_t ctrl;

    pad_iso_usage #(.CNT_W(CNT_W)) u_usage (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .err_clr   (err_clr),
        .busy      (busy),
        .start_up  (start_up),
        .start_dn  (start_dn),
        .unbal_err (unbal_err)
    );

    pad_iso_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .done  (tmr_done)
    );

    pad_iso_steps u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_up (start_up),
        .start_dn (start_dn),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .busy     (busy),
        .ctrl     (ctrl)
    );

    always_comb begin
        iso_word            = '0;
        iso_word[VCORE_BIT] = ctrl.vcore;
        iso_word[EARLY_BIT] = ctrl.early;
        iso_word[CLAMP_BIT] = ctrl.clamp;
    end

    // R1
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iso_word[CLAMP_BIT-1:0] == '0);

endmodule

// File: tb/pad_iso_seq_test.sv
`timescale 1ns/1ps
module pad_iso_seq_test;
    localparam int D  = 4;
    localparam int CW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 1'b0;
    logic        dis_req = 1'b0;
    logic        err_clr = 1'b0;
    logic [31:0] iso_word;
    logic        busy;
    logic        unbal_err;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    pad_iso_seq #(.CNT_W(CW), .DELAY_CYCLES(D)) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .err_clr(err_clr), .iso_word(iso_word), .busy(busy), .unbal_err(unbal_err)
    );

    // op: 0 none, 1 enable, 2 disable, 3 both; iso = expected bits 31..29
    typedef struct packed {
        logic [1:0] op;
        logic       clr;
        logic [2:0] iso;
        logic       err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 3'b000, 1'b0},  // R2 first hold releases
        '{2'd1, 1'b0, 3'b000, 1'b0},  // R3 second hold no change
        '{2'd2, 1'b0, 3'b000, 1'b0},  // R4 drop to one hold
        '{2'd3, 1'b0, 3'b000, 1'b0},  // R10 cancel
        '{2'd2, 1'b0, 3'b111, 1'b0},  // R5 last hold clamps
        '{2'd2, 1'b0, 3'b111, 1'b1},  // R7 unmatched disable
        '{2'd0, 1'b1, 3'b111, 1'b0},  // R8 clear
        '{2'd3, 1'b0, 3'b111, 1'b0},  // R10 cancel at zero
        '{2'd1, 1'b0, 3'b000, 1'b0},  // R2
        '{2'd1, 1'b0, 3'b000, 1'b0},  // R3
        '{2'd1, 1'b0, 3'b000, 1'b0},  // R3 count full
        '{2'd1, 1'b0, 3'b000, 1'b1},  // R9 overflow rejected
        '{2'd0, 1'b1, 3'b000, 1'b0},  // R8
        '{2'd2, 1'b0, 3'b000, 1'b0},  // R4 (proves count stayed 3)
        '{2'd2, 1'b0, 3'b000, 1'b0},  // R4
        '{2'd2, 1'b0, 3'b111, 1'b0}   // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic e, input logic d, input logic c);
        @(negedge clk);
        en_req = e; dis_req = d; err_clr = c;
        @(negedge clk);
        en_req = 1'b0; dis_req = 1'b0; err_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        if (busy) chk("R6 busy timeout", 32'(busy), 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 word", iso_word, 32'hE000_0000);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 err", 32'(unbal_err), 32'd0);

        // R2 release timing
        pulse(1'b1, 1'b0, 1'b0);
        chk("R2 step1", {iso_word[31:29], busy}, {3'b110, 1'b1});
        repeat (D - 1) @(negedge clk);
        chk("R2 hold1", {iso_word[31:29], busy}, {3'b110, 1'b1});
        @(negedge clk);
        chk("R2 step2", {iso_word[31:29], busy}, {3'b100, 1'b1});
        repeat (D - 1) @(negedge clk);
        chk("R2 hold2", {iso_word[31:29], busy}, {3'b100, 1'b1});
        @(negedge clk);
        chk("R2/R6 step3", {iso_word[31:29], busy}, {3'b000, 1'b0});
        chk("R1 spare bits", {3'b000, iso_word[28:0]}, 32'd0);

        // R6 requests during a sequence are dropped
        do_reset();
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        wait_idle();
        chk("R6 after release", iso_word, 32'h0000_0000);
        // R5 assert timing; count must still be one
        pulse(1'b0, 1'b1, 1'b0);
        chk("R5/R6 step1", {iso_word[31:29], busy, unbal_err}, {3'b100, 1'b1, 1'b0});
        repeat (D - 1) @(negedge clk);
        chk("R5 hold1", {iso_word[31:29], busy}, {3'b100, 1'b1});
        @(negedge clk);
        chk("R5 step2", {iso_word[31:29], busy}, {3'b110, 1'b1});
        repeat (D - 1) @(negedge clk);
        chk("R5 hold2", {iso_word[31:29], busy}, {3'b110, 1'b1});
        @(negedge clk);
        chk("R5/R6 step3", {iso_word[31:29], busy}, {3'b111, 1'b0});

        // R8 error set wins over clear in the same cycle
        pulse(1'b0, 1'b1, 1'b1);
        chk("R8 set wins", 32'(unbal_err), 32'd1);
        chk("R7 word kept", iso_word, 32'hE000_0000);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R8 cleared", 32'(unbal_err), 32'd0);

        // vector table
        do_reset();
        for (int k = 0; k < NV; k++) begin
            pulse(VECS[k].op[0], VECS[k].op[1], VECS[k].clr);
            wait_idle();
            chk($sformatf("vec %0d word", k), {29'd0, iso_word[31:29]}, {29'd0, VECS[k].iso});
            chk($sformatf("vec %0d err", k), 32'(unbal_err), 32'(VECS[k].err));
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule